// File: doc/BRIEF.md
# Write-Protected System Control Register Bank

This block holds four 32-bit system control words behind a simple register bus: an address, a write strobe, write data and registered read data. One word carries debug and processor control fields, and it accepts writes only while a separate unlock word has its enable bit set. A second word is that unlock flag. A third word is a fixed identification tag. The fourth word configures two PHY-related controls, and one of those controls can be pinned by a three-bit strap input.

The bank has two synchronous, active-high reset inputs. The hard reset puts every bit back to its reset value. The soft reset does the same for every bit except the memory-enable bit in the control word, which keeps its value across a soft reset. The fields of the control and PHY words also drive output pins directly, so the rest of the chip sees each change on the cycle after the write.

Top module: `sysctl_regbank`

## Requirements
- R1: The words sit at byte offsets 0x650 (control), 0x654 (unlock), 0x658 (tag) and 0x65C (PHY config), decoded from addr[11:2]. `rd_data` returns the addressed word one clock after the address is presented. Any other word offset reads 0 and ignores writes.
- R2: After hard reset the words read control = 0x0000_1939, unlock = 0, tag = 0x0001_0118 and PHY config = 0.
- R3: A write to the control word updates bits 12:9 and 8:0 only when unlock bit 0 is 1. Otherwise the write leaves the word unchanged.
- R4: Control bit 13 reads the `BIG_END` parameter (default 0) and no write changes it. Control bits 31:14 always read 0.
- R5: Only bit 0 of the unlock word is stored and written. Its bits 31:1 read 0.
- R6: Soft reset restores control to 0x1939 with bit 9 unchanged, unlock to 0 and PHY config to 0. Only hard reset clears control bit 9.
- R7: The tag word always reads 0x0001_0118, and writes to it have no effect.
- R8: PHY config bits 16 (PHY reset source) and 13 (port-2 auto-MDIX enable) are writable. All its other bits read 0.
- R9: While `cfg_strap` equals 3'b111, PHY config bit 13 ignores writes and holds its reset value 0.
- R10: The outputs mirror the stored fields: `opt_field` = control[8:0], `tcm_en` = [9], `sync_bypass` = [10], `dbg_en` = [11], `cpu_clk_free` = [12], `cpu_big_endian` = [13], `phy_rst_sel` = PHY[16], `p2_mdix_en` = PHY[13].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst | input | 1 | Synchronous active-high full reset |
| soft_rst | input | 1 | Synchronous active-high reset that spares control bit 9 |
| addr | input | 12 | Byte address within the window |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| cfg_strap | input | 3 | Configuration strap pattern |
| opt_field | output | 9 | Trace option field |
| tcm_en | output | 1 | Tightly coupled memory enable |
| sync_bypass | output | 1 | Debug clock synchronizer bypass |
| dbg_en | output | 1 | Debugger enable |
| cpu_clk_free | output | 1 | Processor clock free-running (1) or gated on wait-for-interrupt (0) |
| cpu_big_endian | output | 1 | Fixed endianness indication |
| phy_rst_sel | output | 1 | PHY reset source select |
| p2_mdix_en | output | 1 | Port-2 auto-MDIX enable |

## Verification
The bench writes all-ones, all-zeros, alternating and walking-one patterns to every word, with the unlock bit both clear and set and with the strap both locked and free. It then reads every word back and compares each value against a model built from the requirements. If the lock gate were wrong, a locked write would show up in the control word. If a reserved bit or bit 13 could be written, it would read back as 1.

Soft resets are issued with control bit 9 set and with it clear. A bank that cleared bit 9 on a soft reset would lose the memory enable. The bench also sweeps all 1024 word offsets and expects 0 from the unmapped ones, which exposes any aliasing in the decoder.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned WORD_W = 32;

  localparam logic [8:0]  OPT_RST  = 9'h139;
  localparam logic [2:0]  HI_RST   = 3'b110;   // bits 12:10
  localparam logic [31:0] TAG_WORD = 32'h0001_0118;

  localparam int unsigned PHY_SRC_BIT  = 16;
  localparam int unsigned PHY_MDIX_BIT = 13;

  typedef enum logic [1:0] {
    SLOT_CTRL = 2'd0,
    SLOT_UNL  = 2'd1,
    SLOT_TAG  = 2'd2,
    SLOT_PHY  = 2'd3
  } slot_e;
endpackage

// File: rtl/sysctl_dbgctl.sv
module sysctl_dbgctl
  import sysctl_pkg::*;
#(
  parameter logic BIG_END = 1'b0
) (
  input  logic        clk,
  input  logic        hard_rst,
  input  logic        soft_rst,
  input  logic        wr_ctrl,
  input  logic        wr_unl,
  input  logic [12:0] wdata,
  output logic [31:0] ctrl_word,
  output logic        unl_bit
);
  logic [8:0] opt_q;
  logic [2:0] hi_q;
  logic       tcm_q;
  logic       ctrl_open;

  assign ctrl_open = wr_ctrl && unl_bit;

  always_ff @(posedge clk) begin
    if (hard_rst || soft_rst) begin
      unl_bit <= 1'b0;
    end else if (wr_unl) begin
      unl_bit <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (hard_rst || soft_rst) begin
      opt_q <= OPT_RST;
      hi_q  <= HI_RST;
    end else if (ctrl_open) begin
      opt_q <= wdata[8:0];
      hi_q  <= wdata[12:10];
    end
  end

  // bit 9 lives in the hard reset domain only
  always_ff @(posedge clk) begin
    if (hard_rst) begin
      tcm_q <= 1'b0;
    end else if (ctrl_open && !soft_rst) begin
      tcm_q <= wdata[9];
    end
  end

  assign ctrl_word = {18'd0, BIG_END, hi_q, tcm_q, opt_q};

  // R3
  locked_write_chk: assert property (@(posedge clk) disable iff (hard_rst || soft_rst)
    (wr_ctrl && !unl_bit) |=> $stable(ctrl_word));

  // R6
  soft_keeps_tcm_chk: assert property (@(posedge clk) disable iff (hard_rst)
    soft_rst |=> (ctrl_word[9] == $past(ctrl_word[9])));
endmodule

// File: rtl/sysctl_phycfg.sv
module sysctl_phycfg
  import sysctl_pkg::*;
#(
  parameter int unsigned  STRAP_W    = 3,
  parameter logic [STRAP_W-1:0] LOCK_PAT = '1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic               src_in,
  input  logic               mdix_in,
  input  logic [STRAP_W-1:0] strap,
  output logic [31:0]        cfg_word
);
  logic src_q;
  logic mdix_q;
  logic pinned;

  assign pinned = (strap == LOCK_PAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= 1'b0;
    end else if (wr) begin
      src_q <= src_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || pinned) begin
      mdix_q <= 1'b0;
    end else if (wr) begin
      mdix_q <= mdix_in;
    end
  end

  always_comb begin
    cfg_word = '0;
    cfg_word[PHY_SRC_BIT]  = src_q;
    cfg_word[PHY_MDIX_BIT] = mdix_q;
  end

  // R9
  strap_pin_chk: assert property (@(posedge clk) disable iff (rst)
    pinned |=> (cfg_word[PHY_MDIX_BIT] == 1'b0));
endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
  import sysctl_pkg::*;
#(
  parameter int unsigned SLOTS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SLOTS-1:0] sel,
  input  logic [31:0]      ctrl_word,
  input  logic [31:0]      unl_word,
  input  logic [31:0]      phy_word,
  output logic [31:0]      rd_data
);
  logic [31:0] slot_val [SLOTS];
  logic [31:0] mux_out;

  assign slot_val[SLOT_CTRL] = ctrl_word;
  assign slot_val[SLOT_UNL]  = unl_word;
  assign slot_val[SLOT_TAG]  = TAG_WORD;
  assign slot_val[SLOT_PHY]  = phy_word;

  always_comb begin
    mux_out = '0;
    for (int k = 0; k < SLOTS; k++) begin
      if (sel[k]) mux_out = mux_out | slot_val[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= mux_out;
  end

  // R1
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == '0) |=> (rd_data == 32'd0));

  // R5
  unl_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    sel[SLOT_UNL] |=> (rd_data[31:1] == 31'd0));

  // R4
  ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    sel[SLOT_CTRL] |=> (rd_data[31:14] == 18'd0));

  // R1
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(sel));
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned STRAP_W   = 3,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h650,
  parameter logic [STRAP_W-1:0] LOCK_PAT = 3'b111,
  parameter logic BIG_END = 1'b0
) (
  input  logic               clk,
  input  logic               hard_rst,
  input  logic               soft_rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  output logic [31:0]        rd_data,
  input  logic [STRAP_W-1:0] cfg_strap,
  output logic [8:0]         opt_field,
  output logic               tcm_en,
  output logic               sync_bypass,
  output logic               dbg_en,
  output logic               cpu_clk_free,
  output logic               cpu_big_endian,
  output logic               phy_rst_sel,
  output logic               p2_mdix_en
);
  localparam int unsigned SLOTS  = 4;
  localparam int unsigned WADR_W = ADDR_W - 2;
  localparam logic [WADR_W-1:0] BASE_WORD = BASE_ADDR[ADDR_W-1:2];

  logic [WADR_W-1:0] word_adr;
  logic [SLOTS-1:0]  sel;
  logic [SLOTS-1:0]  wsel;
  logic [31:0]       ctrl_word;
  logic [31:0]       phy_word;
  logic              unl_bit;
  logic              any_rst;

  assign any_rst  = hard_rst || soft_rst;
  assign word_adr = addr[ADDR_W-1:2];

  for (genvar g = 0; g < SLOTS; g++) begin : g_dec
    assign sel[g]  = (word_adr == BASE_WORD + WADR_W'(g));
    assign wsel[g] = sel[g] && wr_en;
  end

  sysctl_dbgctl #(.BIG_END(BIG_END)) i_dbgctl (
    .clk       (clk),
    .hard_rst  (hard_rst),
    .soft_rst  (soft_rst),
    .wr_ctrl   (wsel[SLOT_CTRL]),
    .wr_unl    (wsel[SLOT_UNL]),
    .wdata     (wr_data[12:0]),
    .ctrl_word (ctrl_word),
    .unl_bit   (unl_bit)
  );

  sysctl_phycfg #(.STRAP_W(STRAP_W), .LOCK_PAT(LOCK_PAT)) i_phycfg (
    .clk      (clk),
    .rst      (any_rst),
    .wr       (wsel[SLOT_PHY]),
    .src_in   (wr_data[PHY_SRC_BIT]),
    .mdix_in  (wr_data[PHY_MDIX_BIT]),
    .strap    (cfg_strap),
    .cfg_word (phy_word)
  );

  sysctl_rdmux #(.SLOTS(SLOTS)) i_rdmux (
    .clk       (clk),
    .rst       (any_rst),
    .sel       (sel),
    .ctrl_word (ctrl_word),
    .unl_word  ({31'd0, unl_bit}),
    .phy_word  (phy_word),
    .rd_data   (rd_data)
  );

  assign opt_field      = ctrl_word[8:0];
  assign tcm_en         = ctrl_word[9];
  assign sync_bypass    = ctrl_word[10];
  assign dbg_en         = ctrl_word[11];
  assign cpu_clk_free   = ctrl_word[12];
  assign cpu_big_endian = ctrl_word[13];
  assign phy_rst_sel    = phy_word[PHY_SRC_BIT];
  assign p2_mdix_en     = phy_word[PHY_MDIX_BIT];

  // R2
  hard_rst_val_chk: assert property (@(posedge clk)
    hard_rst |=> (ctrl_word == {18'd0, BIG_END, 13'h1939} && !unl_bit && phy_word == 32'd0));
endmodule

// File: tb/test_sysctl_regbank.sv
`timescale 1ns/1ps
module test_sysctl_regbank;
  logic        clk = 1'b0;
  logic        hard_rst, soft_rst, wr_en;
  logic [11:0] addr;
  logic [31:0] wr_data, rd_data;
  logic [2:0]  cfg_strap;
  logic [8:0]  opt_field;
  logic tcm_en, sync_bypass, dbg_en, cpu_clk_free, cpu_big_endian, phy_rst_sel, p2_mdix_en;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_ctrl, m_unl, m_phy;
  localparam logic [31:0] TAG = 32'h0001_0118;

  always #2 clk = ~clk;

  sysctl_regbank i_sysctl_regbank (
    .clk(clk), .hard_rst(hard_rst), .soft_rst(soft_rst), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .cfg_strap(cfg_strap), .opt_field(opt_field),
    .tcm_en(tcm_en), .sync_bypass(sync_bypass), .dbg_en(dbg_en), .cpu_clk_free(cpu_clk_free),
    .cpu_big_endian(cpu_big_endian), .phy_rst_sel(phy_rst_sel), .p2_mdix_en(p2_mdix_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 12'h650 && m_unl[0]) m_ctrl = 32'h0000_1FFF & d & ~32'h0000_2000;
    if (a == 12'h654) m_unl = d & 32'h1;
    if (a == 12'h65C) m_phy = d & (cfg_strap == 3'b111 ? 32'h0001_0000 : 32'h0001_2000);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    @(negedge clk);
    check(req, rd_data, exp);
  endtask

  task automatic check_all(input string tag);
    rd(12'h650, m_ctrl, {tag, " R3 R4 ctrl"});
    rd(12'h654, m_unl,  {tag, " R5 unlock"});
    rd(12'h658, TAG,    {tag, " R7 tag"});
    rd(12'h65C, m_phy,  {tag, " R8 R9 phy"});
    check({tag, " R10 pins ctrl"},
          {18'd0, cpu_big_endian, cpu_clk_free, dbg_en, sync_bypass, tcm_en, opt_field}, m_ctrl);
    check({tag, " R10 pins phy"}, {15'd0, phy_rst_sel, 2'd0, p2_mdix_en, 13'd0}, m_phy);
  endtask

  task automatic do_soft;
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    m_ctrl = 32'h0000_1939 | (m_ctrl & 32'h200); m_unl = 0; m_phy = 0;
  endtask

  task automatic do_hard;
    @(negedge clk); hard_rst = 1'b1;
    @(negedge clk); hard_rst = 1'b0;
    m_ctrl = 32'h0000_1939; m_unl = 0; m_phy = 0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] pats [6];
    hard_rst = 1'b1; soft_rst = 1'b0; wr_en = 1'b0; addr = '0; wr_data = '0; cfg_strap = 3'b000;
    m_ctrl = 32'h0000_1939; m_unl = 0; m_phy = 0;
    repeat (3) @(negedge clk);
    hard_rst = 1'b0;
    // R2 reset values
    check_all("R2 reset");
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0; pats[2] = 32'hAAAA_AAAA;
    pats[3] = 32'h5555_5555; pats[4] = 32'h0000_2200; pats[5] = 32'h0001_0A5F;

    // sweep patterns x lock x strap (R3 R5 R7 R8 R9)
    for (int s = 0; s < 2; s++) begin
      @(negedge clk); cfg_strap = (s == 1) ? 3'b111 : 3'b101;
      @(negedge clk);
      if (s == 1) m_phy[13] = 1'b0;
      for (int u = 0; u < 2; u++) begin
        wr(12'h654, u ? 32'hFFFF_FFFF : 32'hFFFF_FFFE);
        for (int p = 0; p < 6; p++) begin
          wr(12'h650, pats[p]);
          wr(12'h658, pats[p]);
          wr(12'h65C, pats[p]);
          check_all("sweep");
        end
        for (int b = 0; b < 32; b++) begin
          wr(12'h650, 32'h1 << b);
          wr(12'h65C, 32'h1 << b);
          check_all("walk");
        end
      end
    end

    // R9 strap applied after bit 13 was set
    @(negedge clk); cfg_strap = 3'b011;
    wr(12'h65C, 32'h0000_2000);
    check_all("R9 free");
    @(negedge clk); cfg_strap = 3'b111;
    @(negedge clk); m_phy[13] = 1'b0;
    check_all("R9 pinned");
    @(negedge clk); cfg_strap = 3'b000;

    // R6 soft reset with bit 9 set, then clear
    wr(12'h654, 32'h1);
    wr(12'h650, 32'h0000_0200);
    wr(12'h65C, 32'h0001_2000);
    do_soft;
    check_all("R6 soft tcm1");
    wr(12'h654, 32'h1);
    wr(12'h650, 32'h0000_1C00);
    do_soft;
    check_all("R6 soft tcm0");
    wr(12'h654, 32'h1);
    wr(12'h650, 32'h0000_0200);
    do_hard;
    check_all("R2 hard clears tcm");

    // R1 sweep all word offsets, unmapped read zero and ignore writes
    for (int w = 0; w < 1024; w++) begin
      logic [11:0] a;
      a = 12'(w << 2);
      if (a < 12'h650 || a > 12'h65C) begin
        wr(a, 32'hFFFF_FFFF);
        rd(a, 32'h0, "R1 unmapped");
      end
    end
    check_all("R1 after unmapped writes");
    rd(12'h659, TAG, "R1 low addr bits ignored");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule